// File: doc/BRIEF.md
# GPIO Function-Select and Output Register Block

This block holds the per-pin configuration and output state for a bank of 54 general-purpose pins behind a 32-bit register port. Each pin has a 3-bit function field. The field selects plain input, plain output, or one of six alternate peripheral sources. Ten fields are packed into each function word. The output latches are changed only by strobe words: a write-one-to-set word and a write-one-to-clear word for each 32-pin bank. Software therefore never needs a read-modify-write to move one pin. Live pin levels are brought back through a synchronizer and read from two level words.

The pad side is a set of flat vectors. The block drives the output value and the output enable for each pin. When a pin is in output mode, both come from its latch. When a pin is in an alternate mode, both are routed from the selected peripheral. When a pin is in input mode, both are held low. The block has no pull control and no event detection.

Top module: `gpio_fnsel_regblk`

## Requirements
- R1: After reset, every function field reads 000 (input), every output latch is 0, and `pad_do_o` and `pad_oe_o` are all zero.
- R2: Pin p's function field sits in the word at byte offset 4*(p/10), at bits 3*(p%10)+2 down to 3*(p%10). A write to that word updates the field in the next cycle, and reading the word returns it. Bits 30 and 31 read 0. Field slots for pins above 53 (word 0x14, bits 12 and up) read 0 and ignore writes.
- R3: Writing to 0x1C (pins 0-31) or 0x20 (pins 32-53, bit p-32) sets the output latch of every pin whose bit is 1. Bits written as 0 leave their latches unchanged, and both words read as 0.
- R4: Writing to 0x28 (pins 0-31) or 0x2C (pins 32-53) clears the output latch of every pin whose bit is 1. Bits written as 0 leave their latches unchanged, and both words read as 0.
- R5: Word 0x34 returns the levels of pins 0-31 and word 0x38 returns pins 32-53 in bits 21:0. A level reaches the read data SYNC_STAGES (default 2) clock edges after it appears on `pad_in_i`. Bits 22-31 of 0x38 read 0, and writes to either word have no effect.
- R6: With function code 001 (output), `pad_oe_o[p]` is 1 and `pad_do_o[p]` equals the pin's output latch.
- R7: With function code 000 (input), `pad_oe_o[p]` and `pad_do_o[p]` are 0. The latch keeps its value through input and alternate modes and drives the pad again when the pin returns to output.
- R8: Codes 100, 101, 110, 111, 011 and 010 select alternate sources 0, 1, 2, 3, 4 and 5. In an alternate mode, `pad_do_o[p]` and `pad_oe_o[p]` equal `alt_do_i[a*54+p]` and `alt_oe_i[a*54+p]`, where a is the source index.
- R9: Addresses other than 0x00-0x14, 0x1C, 0x20, 0x28, 0x2C, 0x34 and 0x38 read 0. Writes to them change no function field and no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| pad_in_i | input | 54 | Live pin levels |
| alt_do_i | input | 324 | Alternate source output values, source a at bits a*54+p |
| alt_oe_i | input | 324 | Alternate source output enables, same layout |
| pad_do_o | output | 54 | Output value to each pad |
| pad_oe_o | output | 54 | Output enable to each pad |

## Verification
A corrupted function field shows up on `pad_oe_o` and `pad_do_o` in the same cycle, because the pad mux is combinational on the stored field. It also shows up in the readback of its word. A field packed at the wrong shift, or mapped to the wrong alternate source, is therefore visible on the first compare after the write. A latch that misses a set or clear, or moves on a zero bit, can hide while its pin is in input or alternate mode. For that reason the stimulus keeps many pins in output mode and switches pins back to output after they have been parked in other modes. A synchronizer with the wrong depth shifts the level readback by one cycle, which the per-clock model compare catches.

// File: rtl/gpio_fnsel_pkg.sv
package gpio_fnsel_pkg;

  localparam int FN_W            = 3;
  localparam int FIELDS_PER_WORD = 10;
  localparam int BANK_W          = 32;
  localparam int WORD_BYTES      = 4;
  localparam int NUM_ALT         = 6;
  localparam int ALT_SEL_W       = $clog2(NUM_ALT);

  // byte offsets; software decodes these
  localparam int FSEL_BASE = 'h00;
  localparam int SET_BASE  = 'h1C;
  localparam int CLR_BASE  = 'h28;
  localparam int LEV_BASE  = 'h34;

  typedef enum logic [FN_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } fn_e;

  function automatic logic is_alt(fn_e f);
    return (f != FN_INPUT) && (f != FN_OUTPUT);
  endfunction

  function automatic logic [ALT_SEL_W-1:0] alt_index(fn_e f);
    case (f)
      FN_ALT0: return ALT_SEL_W'(0);
      FN_ALT1: return ALT_SEL_W'(1);
      FN_ALT2: return ALT_SEL_W'(2);
      FN_ALT3: return ALT_SEL_W'(3);
      FN_ALT4: return ALT_SEL_W'(4);
      FN_ALT5: return ALT_SEL_W'(5);
      default: return ALT_SEL_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank import gpio_fnsel_pkg::*; #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [FIELDS_PER_WORD*FN_W-1:0]    wdata_i,
  output logic [NUM_PINS*FN_W-1:0]           fsel_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
    localparam int WORD  = p / FIELDS_PER_WORD;
    localparam int SHIFT = FN_W * (p % FIELDS_PER_WORD);
    localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(FSEL_BASE + WORD_BYTES * WORD);

    logic [FN_W-1:0] field_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    field_q <= FN_INPUT;
      else if (we_i && addr_i == ADDR) field_q <= wdata_i[SHIFT +: FN_W];
    end

    assign fsel_o[p*FN_W +: FN_W] = field_q;
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch import gpio_fnsel_pkg::*; #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BANK_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] latch_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / BANK_W;
    localparam int BIT  = p % BANK_W;
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(SET_BASE + WORD_BYTES * BANK);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_BASE + WORD_BYTES * BANK);

    logic set_hit, clr_hit, bit_q;

    assign set_hit = we_i && (addr_i == SET_ADDR) && wdata_i[BIT];
    assign clr_hit = we_i && (addr_i == CLR_ADDR) && wdata_i[BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bit_q <= 1'b0;
      else if (set_hit) bit_q <= 1'b1;
      else if (clr_hit) bit_q <= 1'b0;
    end

    assign latch_o[p] = bit_q;
  end

endmodule

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int NUM_PINS = 54,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] level_o
);

  if (STAGES == 0) begin : g_bypass
    assign level_o = pad_in_i;
  end else begin : g_chain
    logic [NUM_PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
        stage_q[0] <= pad_in_i;
        for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
    end

    assign level_o = stage_q[STAGES-1];
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux import gpio_fnsel_pkg::*; #(
  parameter int NUM_PINS = 54
) (
  input  logic [NUM_PINS*FN_W-1:0]    fsel_i,
  input  logic [NUM_PINS-1:0]         latch_i,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_do_i,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0]         pad_do_o,
  output logic [NUM_PINS-1:0]         pad_oe_o
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    fn_e                  fn;
    logic [NUM_ALT-1:0]   src_do, src_oe;
    logic [ALT_SEL_W-1:0] sel;

    assign fn  = fn_e'(fsel_i[p*FN_W +: FN_W]);
    assign sel = alt_index(fn);

    for (genvar a = 0; a < NUM_ALT; a++) begin : g_src
      assign src_do[a] = alt_do_i[a*NUM_PINS + p];
      assign src_oe[a] = alt_oe_i[a*NUM_PINS + p];
    end

    always_comb begin
      pad_do_o[p] = 1'b0;
      pad_oe_o[p] = 1'b0;
      if (fn == FN_OUTPUT) begin
        pad_do_o[p] = latch_i[p];
        pad_oe_o[p] = 1'b1;
      end else if (is_alt(fn)) begin
        pad_do_o[p] = src_do[sel];
        pad_oe_o[p] = src_oe[sel];
      end
    end
  end

endmodule

// File: rtl/gpio_fnsel_regblk.sv
module gpio_fnsel_regblk import gpio_fnsel_pkg::*; #(
  parameter int NUM_PINS    = 54,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [BANK_W-1:0]           reg_wdata_i,
  output logic [BANK_W-1:0]           reg_rdata_o,
  input  logic [NUM_PINS-1:0]         pad_in_i,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_do_i,
  input  logic [NUM_ALT*NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0]         pad_do_o,
  output logic [NUM_PINS-1:0]         pad_oe_o
);

  localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int NUM_FWORDS = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int FWORD_BITS = FIELDS_PER_WORD * FN_W;

  logic [NUM_PINS*FN_W-1:0]         fsel_q;
  logic [NUM_PINS-1:0]              latch_q;
  logic [NUM_PINS-1:0]              level_q;
  logic [NUM_FWORDS*FWORD_BITS-1:0] fsel_pad;
  logic [NUM_BANKS*BANK_W-1:0]      level_pad;

  gpio_fsel_bank #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_fsel_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[FWORD_BITS-1:0]),
    .fsel_o  (fsel_q)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_out_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .latch_o (latch_q)
  );

  gpio_level_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_level_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pad_in_i (pad_in_i),
    .level_o  (level_q)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) i_pad_mux (
    .fsel_i   (fsel_q),
    .latch_i  (latch_q),
    .alt_do_i (alt_do_i),
    .alt_oe_i (alt_oe_i),
    .pad_do_o (pad_do_o),
    .pad_oe_o (pad_oe_o)
  );

  // zero-extend so unused field slots and bank bits read 0
  assign fsel_pad  = (NUM_FWORDS*FWORD_BITS)'(fsel_q);
  assign level_pad = (NUM_BANKS*BANK_W)'(level_q);

  // strobe words fall through to 0
  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < NUM_FWORDS; w++) begin
      if (reg_addr_i == ADDR_W'(FSEL_BASE + WORD_BYTES * w))
        reg_rdata_o[FWORD_BITS-1:0] = fsel_pad[w*FWORD_BITS +: FWORD_BITS];
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i == ADDR_W'(LEV_BASE + WORD_BYTES * b))
        reg_rdata_o = level_pad[b*BANK_W +: BANK_W];
    end
  end

endmodule

// File: rtl/gpio_fnsel_chk.sv
module gpio_fnsel_chk import gpio_fnsel_pkg::*; #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        reg_we_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic [BANK_W-1:0]           reg_wdata_i,
  input logic [BANK_W-1:0]           reg_rdata_o,
  input logic [NUM_ALT*NUM_PINS-1:0] alt_do_i,
  input logic [NUM_PINS-1:0]         pad_do_o,
  input logic [NUM_PINS-1:0]         pad_oe_o,
  input logic [NUM_PINS*FN_W-1:0]    fsel_i,
  input logic [NUM_PINS-1:0]         latch_i
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  logic strobe_addr;
  always_comb begin
    strobe_addr = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i == ADDR_W'(SET_BASE + WORD_BYTES * b) ||
          reg_addr_i == ADDR_W'(CLR_BASE + WORD_BYTES * b))
        strobe_addr = 1'b1;
    end
  end

  p_strobe_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_addr |-> reg_rdata_o == '0);

  p_fsel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(fsel_i));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / BANK_W;
    localparam int BIT  = p % BANK_W;
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(SET_BASE + WORD_BYTES * BANK);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_BASE + WORD_BYTES * BANK);

    logic [FN_W-1:0] fn;
    assign fn = fsel_i[p*FN_W +: FN_W];

    p_out_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn == FN_OUTPUT |-> pad_oe_o[p] && pad_do_o[p] == latch_i[p]);

    p_in_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn == FN_INPUT |-> !pad_oe_o[p] && !pad_do_o[p]);

    p_alt0_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn == FN_ALT0 |-> pad_do_o[p] == alt_do_i[p]);

    p_set_hits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i && reg_addr_i == SET_ADDR && reg_wdata_i[BIT] |=> latch_i[p]);

    p_clr_hits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i && reg_addr_i == CLR_ADDR && reg_wdata_i[BIT] |=> !latch_i[p]);

    p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_we_i && (reg_addr_i == SET_ADDR || reg_addr_i == CLR_ADDR)) |=> $stable(latch_i[p]));
  end

endmodule

bind gpio_fnsel_regblk gpio_fnsel_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_gpio_fnsel_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .alt_do_i    (alt_do_i),
  .pad_do_o    (pad_do_o),
  .pad_oe_o    (pad_oe_o),
  .fsel_i      (fsel_q),
  .latch_i     (latch_q)
);

// File: tb/test_gpio_fnsel_regblk.sv
module test_gpio_fnsel_regblk;

  localparam int N = 54;
  localparam int A = 6;
  localparam int S = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           reg_we_i = 1'b0;
  logic [7:0]     reg_addr_i = '0;
  logic [31:0]    reg_wdata_i = '0;
  logic [31:0]    reg_rdata_o;
  logic [N-1:0]   pad_in_i = '0;
  logic [A*N-1:0] alt_do_i = '0;
  logic [A*N-1:0] alt_oe_i = '0;
  logic [N-1:0]   pad_do_o;
  logic [N-1:0]   pad_oe_o;

  gpio_fnsel_regblk i_gpio_fnsel_regblk (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pad_in_i(pad_in_i),
    .alt_do_i(alt_do_i), .alt_oe_i(alt_oe_i), .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o)
  );

  always #10 clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int           fsel_m [N];
  logic [N-1:0] latch_m = '0;
  logic [N-1:0] sync_m [S];

  function automatic int alt_of(int code);
    case (code)
      4: return 0;
      5: return 1;
      6: return 2;
      7: return 3;
      3: return 4;
      2: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rdata(logic [7:0] a);
    int ai = int'(a);
    logic [31:0] r = '0;
    if (ai % 4 == 0 && ai <= 20) begin
      for (int k = 0; k < 10; k++) begin
        int p = 10 * (ai / 4) + k;
        if (p < N) r = r | (32'(fsel_m[p]) << (3 * k));
      end
    end else if (ai == 52 || ai == 56) begin
      for (int i = 0; i < 32; i++) begin
        int p = 32 * ((ai - 52) / 4) + i;
        if (p < N && sync_m[S-1][p]) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic model_clock();
    int ai = int'(reg_addr_i);
    if (reg_we_i) begin
      if (ai % 4 == 0 && ai <= 20) begin
        for (int k = 0; k < 10; k++) begin
          int p = 10 * (ai / 4) + k;
          if (p < N) fsel_m[p] = int'((reg_wdata_i >> (3 * k)) & 32'h7);
        end
      end else if (ai == 28 || ai == 32 || ai == 40 || ai == 44) begin
        int base = (ai == 32 || ai == 44) ? 32 : 0;
        for (int i = 0; i < 32; i++) begin
          int p = base + i;
          if (p < N && reg_wdata_i[i]) latch_m[p] = (ai < 36);
        end
      end
    end
    for (int s = S - 1; s > 0; s--) sync_m[s] = sync_m[s-1];
    sync_m[0] = pad_in_i;
  endtask

  task automatic compare();
    int bad = -1;
    logic edo = 1'b0, eoe = 1'b0, bdo = 1'b0, boe = 1'b0;
    string btag = "";
    logic [31:0] er;
    string rtag;
    for (int p = 0; p < N; p++) begin
      string tag;
      int code = fsel_m[p];
      if (code == 1) begin
        edo = latch_m[p]; eoe = 1'b1; tag = "R6";
      end else if (code == 0) begin
        edo = 1'b0; eoe = 1'b0; tag = "R7";
      end else begin
        edo = alt_do_i[alt_of(code)*N + p];
        eoe = alt_oe_i[alt_of(code)*N + p];
        tag = "R8";
      end
      if (bad < 0 && (pad_do_o[p] !== edo || pad_oe_o[p] !== eoe)) begin
        bad = p; bdo = edo; boe = eoe; btag = tag;
      end
    end
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s pin %0d do/oe: actual %b/%b expected %b/%b",
               btag, bad, pad_do_o[bad], pad_oe_o[bad], bdo, boe);
    end
    er = exp_rdata(reg_addr_i);
    case (int'(reg_addr_i))
      0, 4, 8, 12, 16, 20: rtag = "R2";
      28, 32:              rtag = "R3";
      40, 44:              rtag = "R4";
      52, 56:              rtag = "R5";
      default:             rtag = "R9";
    endcase
    n_tests++;
    if (reg_rdata_o !== er) begin
      n_fail++;
      $display("FAIL %s read @%02h: actual %08h expected %08h", rtag, reg_addr_i, reg_rdata_o, er);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    if (rst_ni) model_clock();
    @(negedge clk_i);
    compare();
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    reg_addr_i = a;
    step();
  endtask

  initial begin
    int codes [6] = '{4, 5, 6, 7, 3, 2};
    logic [7:0] addrs [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                               8'h20, 8'h24, 8'h28, 8'h2C, 8'h34, 8'h38, 8'h3C, 8'hFC};
    for (int p = 0; p < N; p++) fsel_m[p] = 0;
    for (int s = 0; s < S; s++) sync_m[s] = '0;

    repeat (3) @(negedge clk_i);
    compare();
    chk("R1", "pad_oe in reset", 64'(pad_oe_o), 64'h0);
    chk("R1", "pad_do in reset", 64'(pad_do_o), 64'h0);
    rst_ni = 1'b1;
    rd(8'h00);
    chk("R1", "fsel word 0 after reset", 64'(reg_rdata_o), 64'h0);
    rd(8'h14);
    chk("R1", "fsel word 5 after reset", 64'(reg_rdata_o), 64'h0);

    // pin 5 output, set, park as input, return
    wr(8'h00, 32'h1 << 15);
    chk("R6", "pin5 oe in output mode", 64'(pad_oe_o[5]), 64'h1);
    wr(8'h1C, 32'h1 << 5);
    chk("R3", "pin5 latch set", 64'(pad_do_o[5]), 64'h1);
    wr(8'h1C, 32'h0);
    chk("R3", "zero set word no effect", 64'(pad_do_o[5]), 64'h1);
    rd(8'h1C);
    chk("R3", "set word reads 0", 64'(reg_rdata_o), 64'h0);
    wr(8'h00, 32'h0);
    chk("R7", "pin5 oe in input mode", 64'(pad_oe_o[5]), 64'h0);
    chk("R7", "pin5 do in input mode", 64'(pad_do_o[5]), 64'h0);
    wr(8'h00, 32'h1 << 15);
    chk("R7", "pin5 latch retained", 64'(pad_do_o[5]), 64'h1);
    wr(8'h28, ~(32'h1 << 5));
    chk("R4", "clear of other bits leaves pin5", 64'(pad_do_o[5]), 64'h1);
    wr(8'h28, 32'h1 << 5);
    chk("R4", "pin5 latch cleared", 64'(pad_do_o[5]), 64'h0);
    rd(8'h2C);
    chk("R4", "clear word reads 0", 64'(reg_rdata_o), 64'h0);

    // highest pin: word 0x14 field 3, bank 1 bit 21
    wr(8'h14, 32'h1 << 9);
    wr(8'h20, 32'h1 << 21);
    chk("R3", "pin53 set via bank1", 64'(pad_do_o[53]), 64'h1);
    for (int k = 0; k < 6; k++) begin
      alt_do_i = '0; alt_oe_i = '0;
      for (int a = 0; a < A; a++) alt_oe_i[a*N + 53] = (a != k);
      alt_do_i[k*N + 53] = 1'b1;
      wr(8'h14, 32'(codes[k]) << 9);
      chk("R8", $sformatf("pin53 do via code %0d", codes[k]), 64'(pad_do_o[53]), 64'h1);
      chk("R8", $sformatf("pin53 oe via code %0d", codes[k]), 64'(pad_oe_o[53]), 64'h0);
    end
    wr(8'h14, 32'h1 << 9);
    chk("R7", "pin53 latch kept over alt modes", 64'(pad_do_o[53]), 64'h1);

    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14);
    chk("R2", "word 0x14 unused slots read 0", 64'(reg_rdata_o), 64'h0000_0FFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04);
    chk("R2", "bits 30-31 read 0", 64'(reg_rdata_o), 64'h3FFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h18);
    chk("R9", "unmapped word reads 0", 64'(reg_rdata_o), 64'h0);
    rd(8'h14);
    chk("R9", "unmapped write left fields", 64'(reg_rdata_o), 64'h0000_0FFF);

    // level path latency and masking
    pad_in_i = '1;
    reg_addr_i = 8'h38;
    step();
    chk("R5", "level after one edge", 64'(reg_rdata_o), 64'h0);
    step();
    chk("R5", "level after two edges", 64'(reg_rdata_o), 64'h003F_FFFF);
    wr(8'h34, 32'h0);
    rd(8'h34);
    chk("R5", "level word ignores write", 64'(reg_rdata_o), 64'hFFFF_FFFF);

    // mixed traffic against the model
    for (int c = 0; c < 6000; c++) begin
      int op = int'($urandom % 8);
      pad_in_i = N'({$urandom, $urandom});
      if (c % 8 == 0) begin
        for (int i = 0; i < A * N; i++) begin
          alt_do_i[i] = 1'($urandom);
          alt_oe_i[i] = 1'($urandom);
        end
      end
      reg_we_i = (op < 5);
      reg_addr_i = addrs[$urandom % 16];
      if (op == 0) reg_addr_i = 8'(4 * ($urandom % 6));
      reg_wdata_i = $urandom;
      if (op == 1 && ($urandom % 2) == 1) reg_wdata_i = 32'h2492_4924 | (32'h1 << ($urandom % 32));
      step();
      reg_we_i = 1'b0;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule